// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer. Software must reload its 7-bit down-counter inside a time window. A register port gives access to three words: control, configuration and status. The counter moves once per tick. A tick comes every `BASE_DIV * 2^pre` clock cycles, where `pre` is a 2-bit prescale select and `BASE_DIV` is a fixed base divider (4096 by default).

Once software arms the timer, it raises a one-cycle system reset request in three cases:
- the counter falls from the threshold value (top bit alone set) to the value below it;
- software loads a value whose top bit is clear;
- software reloads the counter while it is still above the programmed window value.

As the counter falls onto the threshold, a warning flag is set. If the warning interrupt is enabled, the flag drives the interrupt line. This lets software reload the counter before the reset request is raised.

Top module: `winwdt_top`

## Requirements
- R1: After a synchronous reset, the registers read as follows. The control word at offset 0x0 reads 0x7F: count 0x7F, bits [6:0]; armed bit 7 clear. The configuration word at offset 0x4 reads 0x07F: window 0x7F in bits [6:0], prescale 0 in bits [8:7], warning enable bit 9 clear. The status word at offset 0x8 reads 0: the flag is bit 0. `rst_req` and `ew_irq` are low.
- R2: The configuration word reads back the window, prescale and warning enable fields that were written. The window accepts any value 0x00 to 0x7F, including values below 0x40.
- R3: The counter decrements once per `BASE_DIV << pre` cycles. A write to the control word loads the count and restarts the divider. The next decrement therefore comes one full period after the write.
- R4: While armed, a decrement from 0x40 to 0x3F raises `rst_req` for exactly one cycle. After a load of 0x41 with no further writes, this happens two periods after the write.
- R5: A control write with bit 6 clear raises `rst_req` on the following cycle if the timer is armed after that write.
- R6: A control write made while already armed raises `rst_req` when the current count is greater than the window. A count equal to or below the window raises nothing.
- R7: Writing 1 to the armed bit arms the timer. Writing 0 there has no effect. Only reset disarms it.
- R8: While not armed, the counter still counts, but no `rst_req` is ever raised.
- R9: The warning flag is set when the counter decrements to 0x40, whether or not the interrupt is enabled. Writing 0 to status bit 0 clears it. Writing 1 leaves it unchanged. If setting and clearing fall in the same cycle, setting wins.
- R10: The warning enable is sticky until reset. `ew_irq` equals enable AND flag, updating in the same cycle as the flag.
- R11: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
The properties take for granted that reset is held for at least one clock edge. They also assume each bus strobe is a clean level sampled on the rising edge, with `bus_wr` and `bus_rd` never high in the same cycle, so a control write is the only source of a load. The reset-request cause checks assume that no write reaches the control word in the cycle that follows a decrement onto the threshold. The bench respects all of this:
- it drives every access on the falling edge;
- it spaces accesses two cycles apart and never overlaps a read with a write;
- it uses a base divider of 4, so every period is short and the cycle at which each warning and reset request appears is computed exactly.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG,
    SEL_STAT
  } reg_sel_e;

  localparam int unsigned OFF_CTRL = 32'h0;
  localparam int unsigned OFF_CFG  = 32'h4;
  localparam int unsigned OFF_STAT = 32'h8;

  function automatic reg_sel_e decode_sel(input logic [31:0] addr);
    reg_sel_e s;
    case (addr)
      OFF_CTRL: s = SEL_CTRL;
      OFF_CFG:  s = SEL_CFG;
      OFF_STAT: s = SEL_STAT;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/winwdt_prediv.sv
module winwdt_prediv #(
  parameter int BASE_DIV = 4096,
  parameter int PRE_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre,
  input  logic             restart,
  output logic             tick
);
  localparam int MAX_SHIFT = (1 << PRE_W) - 1;
  localparam int DIV_W     = $clog2(BASE_DIV) + MAX_SHIFT + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last;

  always_comb last = (DIV_W'(BASE_DIV) << pre) - DIV_W'(1);

  // Reaching or passing the terminal value ends the period, so a smaller
  // prescale chosen mid-period still produces a tick at once.
  assign tick = (div_q >= last) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (div_q >= last) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/winwdt_downcnt.sv
module winwdt_downcnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             set_arm,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             rst_req,
  output logic             warn_hit
);
  localparam logic [CNT_W-1:0] THRESH   = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] PRE_WARN = THRESH + CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             arm_q;
  logic             rreq_q;
  logic             arm_d;
  logic             too_early;
  logic             too_low;
  logic             underflow;
  logic             step;

  assign step      = tick && !load;
  assign arm_d     = arm_q || (load && set_arm);
  assign too_early = load && arm_q && (cnt_q > win);
  assign too_low   = load && arm_d && !load_val[CNT_W-1];
  assign underflow = step && arm_q && (cnt_q == THRESH);
  assign warn_hit  = step && (cnt_q == PRE_WARN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      arm_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      rreq_q <= too_early || too_low || underflow;
      if (load) begin
        cnt_q <= load_val;
      end else if (tick) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt     = cnt_q;
  assign armed   = arm_q;
  assign rst_req = rreq_q;
endmodule

// File: rtl/winwdt_cfgstat.sv
module winwdt_cfgstat #(
  parameter int CNT_W = 7,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] win_in,
  input  logic [PRE_W-1:0] pre_in,
  input  logic             ewi_in,
  input  logic             stat_wr,
  input  logic             flag_in,
  input  logic             warn_hit,
  output logic [CNT_W-1:0] win,
  output logic [PRE_W-1:0] pre,
  output logic             ewi,
  output logic             flag,
  output logic             irq
);
  logic [CNT_W-1:0] win_q;
  logic [PRE_W-1:0] pre_q;
  logic             ewi_q;
  logic             flag_q;
  logic             irq_q;
  logic             ewi_d;
  logic             flag_d;

  always_comb begin
    ewi_d  = ewi_q || (cfg_wr && ewi_in);
    flag_d = flag_q;
    if (stat_wr && !flag_in) flag_d = 1'b0;
    if (warn_hit)            flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '1;
      pre_q  <= '0;
      ewi_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        win_q <= win_in;
        pre_q <= pre_in;
      end
      ewi_q  <= ewi_d;
      flag_q <= flag_d;
      irq_q  <= ewi_d && flag_d;
    end
  end

  assign win  = win_q;
  assign pre  = pre_q;
  assign ewi  = ewi_q;
  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int PRE_W    = 2,
  parameter int BASE_DIV = 4096,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              ew_irq
);
  localparam int ARM_POS = CNT_W;
  localparam int PRE_LSB = CNT_W;
  localparam int EWI_POS = CNT_W + PRE_W;

  reg_sel_e         sel;
  logic             ctrl_wr;
  logic             cfg_wr;
  logic             stat_wr;
  logic             tick;
  logic             warn_hit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] win;
  logic [PRE_W-1:0] pre;
  logic             armed;
  logic             ewi;
  logic             flag;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic             unused_wdata;

  assign sel     = decode_sel(32'(bus_addr));
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign cfg_wr  = bus_wr && (sel == SEL_CFG);
  assign stat_wr = bus_wr && (sel == SEL_STAT);
  assign unused_wdata = ^bus_wdata[DATA_W-1:EWI_POS+1];

  winwdt_prediv #(.BASE_DIV(BASE_DIV), .PRE_W(PRE_W)) u_prediv (
    .clk     (clk),
    .rst     (rst),
    .pre     (pre),
    .restart (ctrl_wr),
    .tick    (tick)
  );

  winwdt_downcnt #(.CNT_W(CNT_W)) u_downcnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (ctrl_wr),
    .load_val (bus_wdata[CNT_W-1:0]),
    .set_arm  (bus_wdata[ARM_POS]),
    .win      (win),
    .cnt      (cnt),
    .armed    (armed),
    .rst_req  (rst_req),
    .warn_hit (warn_hit)
  );

  winwdt_cfgstat #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cfgstat (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .win_in   (bus_wdata[CNT_W-1:0]),
    .pre_in   (bus_wdata[PRE_LSB+PRE_W-1:PRE_LSB]),
    .ewi_in   (bus_wdata[EWI_POS]),
    .stat_wr  (stat_wr),
    .flag_in  (bus_wdata[0]),
    .warn_hit (warn_hit),
    .win      (win),
    .pre      (pre),
    .ewi      (ewi),
    .flag     (flag),
    .irq      (ew_irq)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = DATA_W'({armed, cnt});
      SEL_CFG:  rd_mux = DATA_W'({ewi, pre, win});
      SEL_STAT: rd_mux = DATA_W'(flag);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/winwdt_checker.sv
module winwdt_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] win,
  input logic             armed,
  input logic             ewi,
  input logic             flag,
  input logic             ew_irq,
  input logic             rst_req
);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'(1) << (CNT_W - 1);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_wr) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) - CNT_W'(1))); // R3

  AST_UNDERFLOW_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_wr) && $past(armed) && ($past(cnt) == THRESH) && (cnt != THRESH)) |-> rst_req); // R4

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(ctrl_wr) || ($past(cnt) == THRESH))); // R5

  AST_EARLY_REFRESH: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && armed && (cnt > win)) |=> rst_req); // R6

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(armed) |-> armed); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(armed) && !armed) |-> !rst_req); // R8

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_wr) && ($past(cnt) == THRESH + CNT_W'(1)) && (cnt == THRESH)) |-> flag); // R9

  AST_EWI_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(ewi) |-> ewi); // R10

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    ew_irq == (ewi && flag)); // R10
endmodule

bind winwdt_top winwdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl_wr (ctrl_wr),
  .cnt     (cnt),
  .win     (win),
  .armed   (armed),
  .ewi     (ewi),
  .flag    (flag),
  .ew_irq  (ew_irq),
  .rst_req (rst_req)
);

// File: tb/winwdt_top_bench.sv
module winwdt_top_bench;
  localparam int BASE_DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic        ew_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  winwdt_top #(.BASE_DIV(BASE_DIV)) u_winwdt_top (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .ew_irq    (ew_irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic req_seen);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    req_seen = rst_req;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic watch(input int span, output int n_irq, output int n_req, output int req_cnt);
    n_irq = 0; n_req = 0; req_cnt = 0;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (ew_irq && n_irq == 0) n_irq = i;
      if (rst_req) begin
        if (n_req == 0) n_req = i;
        req_cnt++;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1", "rst_req after reset", 32'(rst_req), 0);
    chk("R1", "ew_irq after reset", 32'(ew_irq), 0);
    rd(4'h0, d); chk("R1", "control word", d, 32'h7F);
    rd(4'h4, d); chk("R1", "config word", d, 32'h07F);
    rd(4'h8, d); chk("R1", "status word", d, 32'h0);
    rd(4'hC, d); chk("R11", "unmapped read", d, 32'h0);
  endtask

  task automatic t_idle();
    logic r; logic [31:0] d; int ni, nr, rc;
    wr(4'h0, 32'h10, r); chk("R8", "low load while idle", 32'(r), 0);
    wr(4'h0, 32'h41, r);
    watch(12, ni, nr, rc);
    chk("R8", "no request on idle underflow", 32'(rc), 0);
    chk("R10", "irq stays low with enable clear", 32'(ni), 0);
    rd(4'h8, d); chk("R9", "flag set with interrupt disabled", d, 32'h1);
    wr(4'h8, 32'h1, r);
    rd(4'h8, d); chk("R9", "writing 1 keeps flag", d, 32'h1);
    wr(4'h8, 32'h0, r);
    rd(4'h8, d); chk("R9", "writing 0 clears flag", d, 32'h0);
    rd(4'h0, d); chk("R8", "still idle", 32'(d[7]), 0);
  endtask

  task automatic t_arm();
    logic r; logic [31:0] d;
    wr(4'h4, 32'h07F, r);
    wr(4'h0, 32'hFF, r); chk("R7", "arming write no request", 32'(r), 0);
    rd(4'h0, d); chk("R7", "armed bit set", 32'(d[7]), 1);
    wr(4'h0, 32'h7F, r); chk("R6", "count equal to window allowed", 32'(r), 0);
    rd(4'h0, d); chk("R7", "writing 0 keeps armed", 32'(d[7]), 1);
  endtask

  task automatic t_window();
    logic r; int ni, nr, rc;
    wr(4'h4, 32'h050, r);
    wr(4'h0, 32'hFF, r); chk("R6", "refresh above window", 32'(r), 1);
    @(negedge clk); chk("R6", "request lasts one cycle", 32'(rst_req), 0);
    watch(200, ni, nr, rc);
    chk("R6", "no request while waiting", 32'(rc), 0);
    wr(4'h0, 32'hFF, r); chk("R6", "refresh below window allowed", 32'(r), 0);
  endtask

  task automatic t_underflow();
    logic r; int ni, nr, rc;
    wr(4'h4, 32'h27F, r);
    wr(4'h0, 32'hC1, r); chk("R4", "load 0x41 no request", 32'(r), 0);
    watch(10, ni, nr, rc);
    chk("R10", "irq cycle after load", 32'(ni), 4);
    chk("R4", "underflow request cycle", 32'(nr), 8);
    chk("R4", "single-cycle request", 32'(rc), 1);
  endtask

  task automatic t_prescale();
    logic r; logic [31:0] d; int ni, nr, rc;
    wr(4'h8, 32'h0, r); chk("R10", "irq drops with flag", 32'(ew_irq), 0);
    wr(4'h4, 32'h0FF, r);
    rd(4'h4, d); chk("R10", "enable sticky, prescale 1 read back", d, 32'h2FF);
    wr(4'h0, 32'hC1, r);
    watch(20, ni, nr, rc);
    chk("R3", "warning at prescale 1", 32'(ni), 8);
    chk("R3", "request at prescale 1", 32'(nr), 16);
    wr(4'h8, 32'h0, r);
    wr(4'h4, 32'h1FF, r);
    wr(4'h0, 32'hC1, r);
    watch(70, ni, nr, rc);
    chk("R3", "warning at prescale 3", 32'(ni), 32);
    chk("R3", "request at prescale 3", 32'(nr), 64);
  endtask

  task automatic t_low_and_cfg();
    logic r; logic [31:0] d;
    wr(4'h0, 32'h85, r); chk("R5", "armed load below threshold", 32'(r), 1);
    wr(4'h4, 32'h020, r);
    rd(4'h4, d); chk("R2", "window below 0x40 kept", d, 32'h220);
    do_reset();
    rd(4'h0, d); chk("R7", "reset disarms", d, 32'h7F);
    rd(4'h4, d); chk("R1", "config after second reset", d, 32'h07F);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_arm();
    t_window();
    t_underflow();
    t_prescale();
    t_low_and_cfg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule